// File: doc/BRIEF.md
# Serial flash command front-end

This block sits between a four-wire serial port and the command logic of a small serial memory. It oversamples the serial clock, chip select and data input with the system clock. It assembles the first byte of each chip-select frame into an opcode and checks that opcode against a parameter table. For table entries that carry an address, it collects a fixed number of address bytes. It then emits one-cycle strobes that a memory back-end can act on: command accepted, address ready, data byte received, and next output byte wanted.

The serial clock may idle low or high, and both cases behave the same. Received bits are taken on the rising serial-clock edge and sent bits change after the falling edge. The most significant bit always comes first. Unknown opcodes and frames cut short during the opcode make the block fall silent until chip select is released. Address bits above the array size are cleared before the address is presented. The memory array, its timing and any status contents belong to the back-end.

Top module: `serial_cmd_frontend`

## Requirements
- R1: In both clock-idle levels, the 8 bits sampled on the first 8 rising edges of the serial clock after chip select falls form the opcode, most significant bit first. A recognised opcode is reported on `cmdCode` with a single-cycle `cmdValid` pulse.
- R2: The default opcode table is 03h (address, data out), 02h (address, data in), 05h (no address, data out) and 06h (no address, no data). Any other opcode produces no `cmdValid`, `addrValid`, `rxValid`, `txReq` or `cmdEnd` until chip select has been released, and the next frame is decoded normally.
- R3: If chip select rises before the 8th opcode bit, no strobe of any kind is produced.
- R4: For an addressed opcode, `addrValid` pulses once after the third following byte. `addrOut` holds those three bytes, the first one in bits 23..16, with bits 23..19 forced to zero.
- R5: Each complete byte received after the opcode (no-address entries) or after the address (addressed entries) gives a single-cycle `rxValid` with that byte on `rxData`. A trailing partial byte gives nothing.
- R6: For a data-out opcode, `txReq` pulses when the opcode or address phase completes, and again after each further complete byte. `txByte` is sampled on the cycle after `txReq`. Its bits appear on `soOut` most significant bit first, each one changing after a falling serial-clock edge, so that it can be read on the next rising edge.
- R7: `soOe` is high only while chip select is asserted and a data-out opcode is in its data phase. `soOut` is 0 whenever `soOe` is low.
- R8: `cmdEnd` pulses once when chip select is released after a recognised opcode, and never otherwise.
- R9: If chip select is released before the third address byte is complete, no `addrValid` and no `rxValid` appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the host, asynchronous |
| csnIn | input | 1 | Chip select, active low, asynchronous |
| siIn | input | 1 | Serial data from the host |
| soOut | output | 1 | Serial data to the host |
| soOe | output | 1 | Output enable for soOut |
| cmdValid | output | 1 | Recognised opcode strobe |
| cmdCode | output | 8 | Accepted opcode |
| cmdWrite | output | 1 | Current opcode has a data-in phase |
| addrValid | output | 1 | Address complete strobe |
| addrOut | output | 24 | Masked address |
| rxValid | output | 1 | Received data byte strobe |
| rxData | output | 8 | Received data byte |
| txReq | output | 1 | Next output byte requested |
| txByte | input | 8 | Output byte from the back-end |
| cmdEnd | output | 1 | Operation closed by chip select |

## Verification
Reads run in both clock-idle levels with an address whose top bits are set. If the two runs agree, the block is not sensitive to the idle level. The set top bits separate a masked address from a passed-through one. Writes, a status read without an address, and a bare opcode show that the table attributes drive the phase sequence. An unknown opcode followed by a valid frame, a five-bit frame, a frame cut inside the address, and a data phase that ends on a partial byte probe the discard and end-of-frame paths.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Opcode table entry: [10:3] opcode, [2] address phase, [1] data in, [0] data out
  localparam int OP_ENTRY_W = 11;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DROP = 2'd3
  } sfcState_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic issueCmd;
    logic captureAddr;
    logic issueAddr;
    logic issueData;
    logic requestTx;
    logic shiftOut;
    logic driveOut;
    logic issueEnd;
  } sfcStrobe_t;

endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  if (STAGES <= 1) begin : g_single
    logic [WIDTH-1:0] stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= RESET_VAL;
      else       stageQ <= din;
    end
    assign dout = stageQ;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= {STAGES{RESET_VAL}};
      else       stageQ <= {stageQ[STAGES-2:0], din};
    end
    assign dout = stageQ[STAGES-1];
  end

endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int ADDR_BITS = 19
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sckS,
  input  logic                    csnS,
  input  logic                    siS,
  input  sfcStrobe_t              stb,
  input  logic [7:0]              txByte,
  output logic                    csActive,
  output logic                    csEnd,
  output logic                    fallStb,
  output logic                    byteDone,
  output logic [7:0]              rxByte,
  output logic                    cmdValid,
  output logic [7:0]              cmdCode,
  output logic                    addrValid,
  output logic [ADDR_BYTES*8-1:0] addrOut,
  output logic                    rxValid,
  output logic [7:0]              rxData,
  output logic                    txReq,
  output logic                    cmdEnd,
  output logic                    soOut,
  output logic                    soOe
);

  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int ACC_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'((64'd1 << ADDR_BITS) - 64'd1);

  logic             sckPrev;
  logic             csPrev;
  logic             riseStb;
  logic [2:0]       bitCnt;
  logic [7:0]       rxShift;
  logic [ACC_W-1:0] addrAcc;
  logic [7:0]       txShift;
  logic             soReg;

  assign csActive = ~csnS;
  assign riseStb  = csActive & sckS & ~sckPrev;
  assign fallStb  = csActive & ~sckS & sckPrev;
  assign csEnd    = csPrev & ~csActive;
  assign rxByte   = rxShift;

  // Bit assembly, rising serial-clock edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      csPrev   <= 1'b0;
      bitCnt   <= 3'd0;
      rxShift  <= 8'd0;
      byteDone <= 1'b0;
    end else begin
      sckPrev  <= sckS;
      csPrev   <= csActive;
      byteDone <= 1'b0;
      if (!csActive) begin
        bitCnt <= 3'd0;
      end else if (riseStb) begin
        rxShift  <= {rxShift[6:0], siS};
        bitCnt   <= bitCnt + 3'd1;
        byteDone <= (bitCnt == 3'd7);
      end
    end
  end

  // Address accumulation and masking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrAcc   <= '0;
      addrOut   <= '0;
      addrValid <= 1'b0;
    end else begin
      addrValid <= stb.issueAddr;
      if (stb.captureAddr) addrAcc <= ACC_W'({addrAcc, rxShift});
      if (stb.issueAddr)   addrOut <= {addrAcc, rxShift} & ADDR_MASK;
    end
  end

  // Registered strobes to the back-end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdCode  <= 8'd0;
      rxValid  <= 1'b0;
      rxData   <= 8'd0;
      txReq    <= 1'b0;
      cmdEnd   <= 1'b0;
    end else begin
      cmdValid <= stb.issueCmd;
      rxValid  <= stb.issueData;
      txReq    <= stb.requestTx;
      cmdEnd   <= stb.issueEnd;
      if (stb.issueCmd)  cmdCode <= rxShift;
      if (stb.issueData) rxData  <= rxShift;
    end
  end

  // Output shifter, advanced on falling serial-clock edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'd0;
      soReg   <= 1'b0;
    end else if (txReq) begin
      txShift <= txByte;
    end else if (stb.shiftOut) begin
      soReg   <= txShift[7];
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign soOe  = stb.driveOut;
  assign soOut = stb.driveOut & soReg;

endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int ADDR_BYTES = 3,
  parameter logic [NUM_OPS*OP_ENTRY_W-1:0] OP_LIST = '0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csActive,
  input  logic       csEnd,
  input  logic       fallStb,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  output sfcStrobe_t stb,
  output logic       cmdWrite
);

  localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [ACW-1:0] ADDR_LAST = ACW'(ADDR_BYTES - 1);

  sfcState_e             state, stateN;
  logic [ACW-1:0]        addrCnt, addrCntN;
  logic                  live, liveN;
  logic                  curOut, curOutN;
  logic                  curIn, curInN;
  logic                  hit, hitAddr, hitIn, hitOut;
  logic [OP_ENTRY_W-1:0] opEntry;

  // Opcode table lookup; the lowest index wins on duplicates
  always_comb begin
    hit = 1'b0;
    hitAddr = 1'b0;
    hitIn = 1'b0;
    hitOut = 1'b0;
    opEntry = '0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      opEntry = OP_LIST[i*OP_ENTRY_W +: OP_ENTRY_W];
      if (opEntry[10:3] == rxByte) begin
        hit = 1'b1;
        hitAddr = opEntry[2];
        hitIn = opEntry[1];
        hitOut = opEntry[0];
      end
    end
  end

  always_comb begin
    stb = '0;
    stateN = state;
    addrCntN = addrCnt;
    liveN = live;
    curOutN = curOut;
    curInN = curIn;
    stb.driveOut = csActive && (state == ST_DATA) && curOut;
    stb.shiftOut = fallStb && stb.driveOut;
    if (csEnd) begin
      stb.issueEnd = live;
      stateN = ST_OPC;
      liveN = 1'b0;
      addrCntN = '0;
    end else if (byteDone) begin
      unique case (state)
        ST_OPC: begin
          if (hit) begin
            stb.issueCmd = 1'b1;
            liveN = 1'b1;
            curOutN = hitOut;
            curInN = hitIn;
            addrCntN = '0;
            if (hitAddr) begin
              stateN = ST_ADDR;
            end else begin
              stateN = ST_DATA;
              stb.requestTx = hitOut;
            end
          end else begin
            stateN = ST_DROP;
          end
        end
        ST_ADDR: begin
          stb.captureAddr = 1'b1;
          addrCntN = addrCnt + ACW'(1);
          if (addrCnt == ADDR_LAST) begin
            stb.issueAddr = 1'b1;
            stb.requestTx = curOut;
            stateN = ST_DATA;
          end
        end
        ST_DATA: begin
          stb.issueData = 1'b1;
          stb.requestTx = curOut;
        end
        ST_DROP: begin
          stateN = ST_DROP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OPC;
      addrCnt <= '0;
      live    <= 1'b0;
      curOut  <= 1'b0;
      curIn   <= 1'b0;
    end else begin
      state   <= stateN;
      addrCnt <= addrCntN;
      live    <= liveN;
      curOut  <= curOutN;
      curIn   <= curInN;
    end
  end

  assign cmdWrite = curIn;

endmodule

// File: rtl/serial_cmd_frontend.sv
module serial_cmd_frontend
  import sfc_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int ADDR_BYTES = 3,
  parameter int ADDR_BITS = 19,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_OPS*OP_ENTRY_W-1:0] OP_LIST =
    {8'h06, 3'b000, 8'h05, 3'b001, 8'h02, 3'b110, 8'h03, 3'b101}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sckIn,
  input  logic                    csnIn,
  input  logic                    siIn,
  output logic                    soOut,
  output logic                    soOe,
  output logic                    cmdValid,
  output logic [7:0]              cmdCode,
  output logic                    cmdWrite,
  output logic                    addrValid,
  output logic [ADDR_BYTES*8-1:0] addrOut,
  output logic                    rxValid,
  output logic [7:0]              rxData,
  output logic                    txReq,
  input  logic [7:0]              txByte,
  output logic                    cmdEnd
);

  logic [2:0] pinSync;
  logic       csActive;
  logic       csEnd;
  logic       fallStb;
  logic       byteDone;
  logic [7:0] rxByte;
  sfcStrobe_t stb;

  sfc_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(3),
    .RESET_VAL(3'b010)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({siIn, csnIn, sckIn}),
    .dout(pinSync)
  );

  sfc_datapath #(
    .ADDR_BYTES(ADDR_BYTES),
    .ADDR_BITS (ADDR_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sckS     (pinSync[0]),
    .csnS     (pinSync[1]),
    .siS      (pinSync[2]),
    .stb      (stb),
    .txByte   (txByte),
    .csActive (csActive),
    .csEnd    (csEnd),
    .fallStb  (fallStb),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .addrValid(addrValid),
    .addrOut  (addrOut),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .txReq    (txReq),
    .cmdEnd   (cmdEnd),
    .soOut    (soOut),
    .soOe     (soOe)
  );

  sfc_control #(
    .NUM_OPS   (NUM_OPS),
    .ADDR_BYTES(ADDR_BYTES),
    .OP_LIST   (OP_LIST)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .csActive(csActive),
    .csEnd   (csEnd),
    .fallStb (fallStb),
    .byteDone(byteDone),
    .rxByte  (rxByte),
    .stb     (stb),
    .cmdWrite(cmdWrite)
  );

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic addrValid,
  input logic rxValid,
  input logic txReq,
  input logic cmdEnd,
  input logic soOe,
  input logic csActive
);

  logic gotCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         gotCmd <= 1'b0;
    else if (cmdEnd)   gotCmd <= 1'b0;
    else if (cmdValid) gotCmd <= 1'b1;
  end

  a_r1_cmd_single: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  a_r4_addr_in_cmd: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> gotCmd);

  a_r5_data_in_cmd: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (gotCmd && !addrValid));

  a_r6_req_in_cmd: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (gotCmd || cmdValid));

  a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> csActive);

  a_r8_end_in_cmd: assert property (@(posedge clk) disable iff (!rstN)
    cmdEnd |-> gotCmd);

endmodule

bind serial_cmd_frontend sfc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .addrValid(addrValid),
  .rxValid  (rxValid),
  .txReq    (txReq),
  .cmdEnd   (cmdEnd),
  .soOe     (soOe),
  .csActive (csActive)
);

// File: tb/sim_serial_cmd_frontend.sv
module sim_serial_cmd_frontend;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sckIn = 1'b0;
  logic        csnIn = 1'b1;
  logic        siIn = 1'b0;
  logic [7:0]  txByte = 8'd0;
  logic        soOut, soOe, cmdValid, cmdWrite, addrValid, rxValid, txReq, cmdEnd;
  logic [7:0]  cmdCode, rxData;
  logic [23:0] addrOut;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  logic [7:0]  mosi[$];
  logic [7:0]  cmdSeen[$];
  logic [7:0]  rxSeen[$];
  logic [7:0]  supplied[$];
  logic [7:0]  soCap[$];
  logic [23:0] addrSeen[$];
  int          txReqCnt = 0;
  int          endCnt = 0;
  int          csnHigh = 0;
  bit          oeAny = 1'b0;
  logic [7:0]  txSeed = 8'h4e;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_cmd_frontend u0 (
    .clk      (clk),
    .rstN     (rstN),
    .sckIn    (sckIn),
    .csnIn    (csnIn),
    .siIn     (siIn),
    .soOut    (soOut),
    .soOe     (soOe),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .cmdWrite (cmdWrite),
    .addrValid(addrValid),
    .addrOut  (addrOut),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .txReq    (txReq),
    .txByte   (txByte),
    .cmdEnd   (cmdEnd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  // Monitor and back-end model, sampled every clock away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (cmdValid)  cmdSeen.push_back(cmdCode);
        if (addrValid) addrSeen.push_back(addrOut);
        if (rxValid)   rxSeen.push_back(rxData);
        if (cmdEnd)    endCnt++;
        if (soOe)      oeAny = 1'b1;
        if (txReq) begin
          txReqCnt++;
          txByte = txSeed;
          supplied.push_back(txSeed);
          txSeed = txSeed + 8'h5d;
        end
        csnHigh = csnIn ? csnHigh + 1 : 0;
        // R7 per-clock: quiet output while idle or disabled
        chk(!(!soOe && soOut), "R7", "soOut low while disabled", soOut, 0);
        if (csnHigh >= 4) chk(!soOe, "R7", "soOe low with chip select idle", soOe, 0);
      end
    end
  end

  function automatic bit isKnown(input logic [7:0] op);
    return (op == 8'h03) || (op == 8'h02) || (op == 8'h05) || (op == 8'h06);
  endfunction

  // Drive one frame from mosi and compare all strobes with the requirements
  task automatic runTxn(input bit mode3, input int nbits, input string tag);
    int nFull;
    logic [7:0] opc;
    bit known, hasAddr, isOut, addrDone;
    int dataStart, nData, expTx;
    logic [7:0] soByte;
    logic [7:0] expRx[$];
    cmdSeen.delete(); rxSeen.delete(); supplied.delete(); soCap.delete(); addrSeen.delete();
    expRx.delete();
    txReqCnt = 0; endCnt = 0; oeAny = 1'b0; soByte = 8'd0;
    nFull = nbits / 8;
    opc = (nFull > 0) ? mosi[0] : 8'h00;
    known = (nFull > 0) && isKnown(opc);
    hasAddr = known && (opc == 8'h03 || opc == 8'h02);
    isOut = known && (opc == 8'h03 || opc == 8'h05);
    addrDone = hasAddr && (nFull >= 4);
    dataStart = hasAddr ? 32 : 8;

    @(negedge clk);
    sckIn = mode3;
    repeat (4) @(negedge clk);
    csnIn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sckIn = 1'b0;
      siIn = mosi[i / 8][7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      if (isOut && i >= dataStart) begin
        soByte = {soByte[6:0], soOut};
        if (((i - dataStart) % 8) == 7) soCap.push_back(soByte);
      end
      sckIn = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    if (!mode3) sckIn = 1'b0;
    repeat (HALF) @(negedge clk);
    csnIn = 1'b1;
    repeat (4 * HALF) @(negedge clk);

    if (known && (!hasAddr || addrDone))
      for (int b = (hasAddr ? 4 : 1); b < nFull; b++) expRx.push_back(mosi[b]);
    nData = expRx.size();
    expTx = (isOut && (!hasAddr || addrDone)) ? 1 + nData : 0;

    chk(cmdSeen.size() == (known ? 1 : 0), tag, "command strobes", cmdSeen.size(), known);
    if (known && cmdSeen.size() == 1) chk(cmdSeen[0] == opc, "R1", "opcode value", cmdSeen[0], opc);
    chk(addrSeen.size() == (addrDone ? 1 : 0), "R4", "address strobes", addrSeen.size(), addrDone);
    if (addrDone && addrSeen.size() == 1)
      chk(addrSeen[0] == ({mosi[1], mosi[2], mosi[3]} & 24'h07FFFF), "R4", "masked address",
          addrSeen[0], {mosi[1], mosi[2], mosi[3]} & 24'h07FFFF);
    chk(rxSeen.size() == nData, "R5", "data strobes", rxSeen.size(), nData);
    for (int k = 0; k < nData && k < rxSeen.size(); k++)
      chk(rxSeen[k] == expRx[k], "R5", "data byte", rxSeen[k], expRx[k]);
    chk(txReqCnt == expTx, "R6", "byte requests", txReqCnt, expTx);
    for (int k = 0; k < soCap.size() && k < supplied.size(); k++)
      chk(soCap[k] == supplied[k], "R6", "serial output byte", soCap[k], supplied[k]);
    if (isOut && (!hasAddr || addrDone))
      chk(soCap.size() == nData, "R6", "output bytes captured", soCap.size(), nData);
    chk(oeAny == (isOut && (!hasAddr || addrDone)), "R7", "output enable seen", oeAny,
        isOut && (!hasAddr || addrDone));
    chk(endCnt == (known ? 1 : 0), "R8", "end strobes", endCnt, known);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    // Reset state
    chk(!soOe && !cmdValid && !addrValid && !rxValid && !txReq && !cmdEnd, "R7",
        "quiet after reset", {soOe, cmdValid, addrValid, rxValid, txReq, cmdEnd}, 0);

    // R1/R4/R6: read, clock idle low, top address bits set
    mosi = '{8'h03, 8'hFF, 8'hAB, 8'hCD, 8'h00, 8'h00};
    runTxn(1'b0, 48, "R1");
    // R1: the same read with clock idle high
    mosi = '{8'h03, 8'hFF, 8'hAB, 8'hCD, 8'h00, 8'h00};
    runTxn(1'b1, 48, "R1");
    // R5: write with three data bytes
    mosi = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hA5, 8'h3C, 8'hF0};
    runTxn(1'b0, 56, "R1");
    chk(cmdWrite == 1'b1, "R5", "write attribute held", cmdWrite, 1);
    // R6: data-out opcode without address, clock idle high
    mosi = '{8'h05, 8'h00, 8'h00};
    runTxn(1'b1, 24, "R1");
    // R8: bare opcode with no further phase
    mosi = '{8'h06};
    runTxn(1'b0, 8, "R8");
    // R2: unknown opcode, then a valid frame decodes normally
    mosi = '{8'h9F, 8'h03, 8'h01, 8'h02, 8'h03, 8'h55};
    runTxn(1'b0, 48, "R2");
    mosi = '{8'h05, 8'h00};
    runTxn(1'b0, 16, "R2");
    // R3: chip select released after five opcode bits
    mosi = '{8'h03};
    runTxn(1'b1, 5, "R3");
    chk(endCnt == 0 && txReqCnt == 0, "R3", "nothing issued on cut opcode", endCnt + txReqCnt, 0);
    // R9: chip select released inside the address
    mosi = '{8'h02, 8'h07, 8'h11, 8'h22};
    runTxn(1'b0, 20, "R9");
    chk(addrSeen.size() == 0 && rxSeen.size() == 0, "R9", "no address on cut frame",
        addrSeen.size() + rxSeen.size(), 0);
    // R5: read ending on a partial data byte
    mosi = '{8'h03, 8'h07, 8'hFF, 8'hFF, 8'h00, 8'h00};
    runTxn(1'b1, 44, "R5");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule